// File: doc/BRIEF.md
# Receive Byte-Boundary Strobe Generator

This block sits on the decoded NRZ receive stream of a 10 Mb/s network port, one bit per cycle of the 10 MHz receive bit clock. It hunts for the alternating preamble and locks on the pair of consecutive ones that closes the start-of-frame delimiter. From the first bit after that pair it produces a square-wave strobe with an 8-bit period. The strobe rises on the first bit of every received byte, starting with the first destination-address bit. External address-recognition logic uses the strobe to line up on byte boundaries.

The block also forwards the serial data, registered once, so that data and strobe leave it in the same cycle. It raises a one-cycle frame-start pulse and keeps a running byte index. Transmit activity or loss of receive activity silences the strobe and sends the detector back to hunting. Within one receive frame the detector locks only once.

Top module: `rx_delim_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, delim_o, frame_start_o and sdata_o are 0 and byte_cnt_o is 0.
- R2: sdata_o equals the rx_data_i value sampled at the previous rising clock edge.
- R3: The trigger is a 1 sampled right after a run of at least MIN_PRE (default 8) alternating bits that ends in a 1. It is only accepted while rx_active_i is 1 and tx_active_i is 0. delim_o rises one cycle after the edge that samples the trigger bit, in the same cycle that sdata_o carries the first bit after the trigger.
- R4: A pair of consecutive ones after fewer than MIN_PRE alternating bits produces no strobe.
- R5: Once triggered, delim_o is 1 for BYTE_BITS/2 (4) cycles and then 0 for 4 cycles, repeating with a period of BYTE_BITS (8) cycles. Bit i after the trigger (i from 0) appears on sdata_o in a cycle where delim_o = 1 exactly when i mod 8 < 4.
- R6: frame_start_o is 1 for exactly one cycle, the cycle of the first strobe rising edge.
- R7: byte_cnt_o is 0 during the first byte after the trigger and then steps by one at each strobe rising edge. For bit i it equals floor(i/8) mod 2^CNT_W (default CNT_W = 8).
- R8: A cycle with tx_active_i = 1 forces delim_o and frame_start_o to 0 from the next cycle on, and clears the lock. A new trigger is needed before the strobe returns.
- R9: A cycle with rx_active_i = 0 forces delim_o to 0 and byte_cnt_o to 0 from the next cycle on. The detector then hunts again, so the next frame triggers normally.
- R10: While locked, a further preamble-like pattern followed by "11" in the data has no effect on delim_o, frame_start_o or byte_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 MHz receive bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_data_i | input | 1 | Decoded NRZ receive bit |
| rx_active_i | input | 1 | Receive activity (carrier) |
| tx_active_i | input | 1 | Transmit in progress |
| sdata_o | output | 1 | Forwarded serial receive data |
| delim_o | output | 1 | Byte-boundary strobe, rises on first bit of each byte |
| frame_start_o | output | 1 | One-cycle pulse at first strobe rise |
| byte_cnt_o | output | CNT_W | Index of the byte being forwarded |

## Verification
The assertions assume that rx_data_i carries one valid bit per clock while rx_active_i is high, and that a frame is carried by one continuous rx_active_i interval. The stimulus changes inputs only on the falling edge, one bit per cycle. Every frame starts after a cycle with rx_active_i low, so the hunter always begins from a cleared state. The tx_active_i pulses are applied mid-frame and are followed by zero data, so no new trigger can be formed before the end of the frame.

// File: rtl/rx_delim_pkg.sv
package rx_delim_pkg;
  typedef enum logic {HUNT = 1'b0, LOCKED = 1'b1} hunt_state_e;

  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/rx_delim_hunt.sv
module rx_delim_hunt
  import rx_delim_pkg::*;
#(
  parameter int unsigned MIN_PRE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic abort_i,
  output logic trig_o
);
  localparam int unsigned AW = $clog2(MIN_PRE + 1);

  hunt_state_e state_q;
  logic [AW-1:0] alt_q;
  logic          prev_q;

  // second 1 after a long enough alternating run ending in 1
  assign trig_o = !abort_i && (state_q == HUNT) && (alt_q >= AW'(MIN_PRE)) && prev_q && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HUNT;
      alt_q   <= '0;
      prev_q  <= 1'b0;
    end else if (abort_i) begin
      state_q <= HUNT;
      alt_q   <= '0;
      prev_q  <= 1'b0;
    end else if (state_q == HUNT) begin
      if (trig_o) begin
        state_q <= LOCKED;
      end else if (alt_q == '0 || bit_i == prev_q) begin
        alt_q  <= AW'(1);
        prev_q <= bit_i;
      end else begin
        alt_q  <= AW'(sat_inc(int'(alt_q), MIN_PRE));
        prev_q <= bit_i;
      end
    end
  end

  // R10
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LOCKED && !abort_i) |=> (state_q == LOCKED));
endmodule

// File: rtl/rx_delim_phase.sv
module rx_delim_phase #(
  parameter int unsigned BYTE_BITS = 8,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             rx_active_i,
  input  logic             tx_active_i,
  output logic             delim_o,
  output logic             frame_start_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  localparam int unsigned PW   = $clog2(BYTE_BITS);
  localparam int unsigned HALF = BYTE_BITS / 2;

  logic             abort;
  logic             trig_q, start_q, in_frame_q;
  logic [PW-1:0]    phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign abort = !rx_active_i || tx_active_i;
  assign wrap  = (phase_q == PW'(BYTE_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q     <= 1'b0;
      start_q    <= 1'b0;
      in_frame_q <= 1'b0;
      phase_q    <= '0;
      cnt_q      <= '0;
    end else if (abort) begin
      trig_q     <= 1'b0;
      start_q    <= 1'b0;
      in_frame_q <= 1'b0;
      phase_q    <= '0;
      cnt_q      <= '0;
    end else begin
      // one-cycle delay aligns strobe with registered data
      trig_q  <= trig_i;
      start_q <= trig_q;
      if (trig_q) begin
        in_frame_q <= 1'b1;
        phase_q    <= '0;
        cnt_q      <= '0;
      end else if (in_frame_q) begin
        phase_q <= wrap ? '0 : phase_q + 1'b1;
        if (wrap) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign delim_o       = in_frame_q && (phase_q < PW'(HALF));
  assign frame_start_o = start_q;
  assign byte_cnt_o    = cnt_q;

  // R8
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> (!delim_o && !frame_start_o));
  // R9
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_active_i |=> (!delim_o && byte_cnt_o == '0));
  // R6
  single_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  // R5
  low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(delim_o) && !abort |=> !delim_o);
endmodule

// File: rtl/rx_delim_gen.sv
module rx_delim_gen #(
  parameter int unsigned MIN_PRE   = 8,
  parameter int unsigned BYTE_BITS = 8,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_data_i,
  input  logic             rx_active_i,
  input  logic             tx_active_i,
  output logic             sdata_o,
  output logic             delim_o,
  output logic             frame_start_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  logic trig;
  logic abort;
  logic sdata_q;
  logic past_ok_q;

  assign abort = !rx_active_i || tx_active_i;

  rx_delim_hunt #(.MIN_PRE(MIN_PRE)) u_hunt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (rx_data_i),
    .abort_i (abort),
    .trig_o  (trig)
  );

  rx_delim_phase #(.BYTE_BITS(BYTE_BITS), .CNT_W(CNT_W)) u_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trig_i        (trig),
    .rx_active_i   (rx_active_i),
    .tx_active_i   (tx_active_i),
    .delim_o       (delim_o),
    .frame_start_o (frame_start_o),
    .byte_cnt_o    (byte_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      sdata_q   <= rx_data_i;
      past_ok_q <= 1'b1;
    end
  end

  assign sdata_o = sdata_q;

  // R2
  sdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |=> (sdata_o == $past(rx_data_i)));
  // R6
  start_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (delim_o && byte_cnt_o == '0));
  // R7
  byte_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(delim_o) && !frame_start_o) |-> (byte_cnt_o == CNT_W'($past(byte_cnt_o) + 1'b1)));
  // R3
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(delim_o) && frame_start_o) |-> $past(rx_active_i && !tx_active_i));
endmodule

// File: tb/rx_delim_gen_test.sv
module rx_delim_gen_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 1'b0, rx_act = 1'b0, tx_act = 1'b0;
  logic sdata, delim, fstart;
  logic [CW-1:0] bcnt;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_delim_gen #(.MIN_PRE(8), .BYTE_BITS(8), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_active_i(rx_act),
    .tx_active_i(tx_act), .sdata_o(sdata), .delim_o(delim),
    .frame_start_o(fstart), .byte_cnt_o(bcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic a, input logic t);
    @(negedge clk);
    rx_data = b; rx_act = a; tx_act = t;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0);
    chk("R9 idle delim", int'(delim), 0);
    chk("R9 idle cnt", int'(bcnt), 0);
  endtask

  // P alternating bits ending in 1, then the closing 1
  task automatic preamble(input int p, input bit expect_trig);
    for (int j = 0; j < p; j++) begin
      step(((p - 1 - j) % 2 == 0), 1'b1, 1'b0);
      chk("R4 preamble quiet", int'(delim), 0);
    end
    step(1'b1, 1'b1, 1'b0);
    chk("R3 trigger cycle quiet", int'(delim), 0);
    chk("R2 sdata", int'(sdata), 1);
  endtask

  task automatic frame_bits(input int nbits, input int seed, input bit trig, input bit rearm_pat);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (!trig) b = 1'b0;
      else if (rearm_pat) b = (i < 16) ? logic'(i % 2) : 1'b1;
      else b = logic'(((i * 37 + seed) >> 2) & 1);
      step(b, 1'b1, 1'b0);
      chk("R2 sdata", int'(sdata), int'(b));
      if (trig) begin
        chk(rearm_pat ? "R10 R5 delim" : "R5 delim", int'(delim), ((i % 8) < 4) ? 1 : 0);
        chk(rearm_pat ? "R10 R7 count" : "R7 count", int'(bcnt), (i / 8) % (1 << CW));
        chk(i == 0 ? "R3 R6 start" : "R6 start", int'(fstart), (i == 0) ? 1 : 0);
      end else begin
        chk("R4 no strobe", int'(delim), 0);
        chk("R4 no start", int'(fstart), 0);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    chk("R1 reset delim", int'(delim), 0);
    chk("R1 reset start", int'(fstart), 0);
    chk("R1 reset cnt", int'(bcnt), 0);
    chk("R1 reset sdata", int'(sdata), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk("R1 post-reset delim", int'(delim), 0);
    chk("R1 post-reset cnt", int'(bcnt), 0);

    // sweep preamble length across the threshold
    for (int p = 2; p <= 14; p++) begin
      idle();
      preamble(p, p >= 8);
      frame_bits(24, p, p >= 8, 1'b0);
    end

    // no re-arm within a frame
    idle();
    preamble(10, 1'b1);
    frame_bits(40, 0, 1'b1, 1'b1);

    // counter wrap
    idle();
    preamble(8, 1'b1);
    frame_bits(8 * 260, 5, 1'b1, 1'b0);

    // transmit activity mid-frame
    idle();
    preamble(9, 1'b1);
    frame_bits(13, 1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk("R8 tx delim", int'(delim), 0);
    chk("R8 tx start", int'(fstart), 0);
    for (int k = 0; k < 12; k++) begin
      step(1'b0, 1'b1, 1'b0);
      chk("R8 stays low", int'(delim), 0);
    end

    // receive drop mid-frame then re-arm
    idle();
    preamble(12, 1'b1);
    frame_bits(10, 3, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R9 drop delim", int'(delim), 0);
    chk("R9 drop cnt", int'(bcnt), 0);
    preamble(8, 1'b1);
    frame_bits(16, 9, 1'b1, 1'b0);

    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule